// File: doc/BRIEF.md
# Tagged Translation Cache with Software Refill

This block is a fully associative cache of virtual-to-physical page translations for 4 KB pages. Every entry is compared against an incoming virtual page number at once. A hit returns the frame number together with the dirty and coherence attribute bits. A miss raises a miss flag, which the surrounding pipeline turns into an exception. The block never reads memory itself. Privileged software refills and maintains the contents through a single command port.

Each entry carries an address-space tag and a global flag, so mappings for several processes can live side by side. A per-context identifier register selects which tagged entries can hit, and global entries hit under any identifier. The command port can search for an entry, read one back, write one at a chosen index, write one at a pseudo-random index, clear all valid bits, set the current identifier and set a wired count. The wired count keeps the lowest entries safe from random replacement.

Top module: `xlt_cache`

## Requirements
- R1: After reset every entry is invalid, the current identifier is 0 and the wired count is 0. Every lookup misses, and a read of any index returns valid=0.
- R2: A lookup with `lk_vld` high hits (`lk_hit`=1) when some entry is valid, has the same page number, and either has its global bit set or carries the current identifier. It then returns that entry's frame number, dirty bit and coherence bits in the same cycle.
- R3: A lookup with `lk_vld` high and no matching entry drives `lk_miss`=1 and `lk_hit`=0. The two flags are never high together.
- R4: Command op 5 loads `cmd_asid` into the current identifier. Non-global entries carrying another identifier then stop hitting, and the identifier holds its value until the next op 5.
- R5: Command op 0 (probe) searches with `cmd_vpn` and the current identifier. One cycle later `rsp_vld`=1 and `rsp_probe` holds the matching index. When nothing matches it holds 32'h8000_0000 (bit 31 set, all other bits 0). When several entries match, the lowest index is reported.
- R6: Command op 1 (read) returns every field of entry `cmd_idx` on the `rsp_*` outputs one cycle later, with `rsp_vld`=1.
- R7: Command op 2 (indexed write) replaces entry `cmd_idx` with the `cmd_*` field values.
- R8: Command op 3 (random write) replaces the entry named by a victim counter. The counter starts at the top index, decrements every clock, and after holding the wired count it returns to the top index. A random write therefore never lands below the wired count.
- R9: Command op 6 loads `cmd_idx` into the wired count. On the next cycle the victim counter is at the top index.
- R10: Command op 4 (flush) clears every valid bit, so no lookup hits on the following cycle.
- R11: A command takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the contents from before the command, and a lookup in the next cycle sees the updated contents. Op 7 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | 19 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup found no mapping (miss exception) |
| lk_pfn | output | 24 | Frame number of the hit entry (0 on miss) |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_coh | output | 3 | Coherence bits of the hit entry |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 probe, 1 read, 2 indexed write, 3 random write, 4 flush, 5 set identifier, 6 set wired, 7 none) |
| cmd_idx | input | log2(N_ENTRIES) | Entry index for read and indexed write, or value for the wired count |
| cmd_vpn | input | 19 | Page number for writes and probe |
| cmd_pfn | input | 24 | Frame number for writes |
| cmd_asid | input | 8 | Identifier for writes and set-identifier |
| cmd_glb | input | 1 | Global bit for writes |
| cmd_dirty | input | 1 | Dirty bit for writes |
| cmd_valid | input | 1 | Valid bit for writes |
| cmd_coh | input | 3 | Coherence bits for writes |
| rsp_vld | output | 1 | Probe or read result available |
| rsp_probe | output | 32 | Probe result: index, or bit 31 set on miss |
| rsp_vpn | output | 19 | Read result page number |
| rsp_pfn | output | 24 | Read result frame number |
| rsp_asid | output | 8 | Read result identifier |
| rsp_glb | output | 1 | Read result global bit |
| rsp_dirty | output | 1 | Read result dirty bit |
| rsp_valid | output | 1 | Read result valid bit |
| rsp_coh | output | 3 | Read result coherence bits |

## Verification
The bench builds the block with the default of 32 entries. This keeps the top index at 31, so victim-counter positions can be worked out by hand. Setting the wired count to 30 leaves only two entries open to random replacement. Three random writes on back-to-back cycles then hit the top index, drop to the wired boundary and wrap back, and the reserved entries below stay unchanged. Two identifiers, one global entry and two entries with the same page number bring the tag rule and the lowest-index probe order within reach.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   localparam int VPN_W  = 19;
   localparam int PFN_W  = 24;
   localparam int ASID_W = 8;
   localparam int COH_W  = 3;

   typedef enum logic [2:0] {
      OP_PROBE     = 3'd0,
      OP_READ      = 3'd1,
      OP_WR_IDX    = 3'd2,
      OP_WR_RND    = 3'd3,
      OP_FLUSH     = 3'd4,
      OP_SET_ASID  = 3'd5,
      OP_SET_WIRED = 3'd6,
      OP_NOP       = 3'd7
   } xlt_op_e;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [PFN_W-1:0]  pfn;
      logic [ASID_W-1:0] asid;
      logic              glb;
      logic              dirty;
      logic              valid;
      logic [COH_W-1:0]  coh;
   } xlt_entry_t;
endpackage

// File: rtl/xlt_match.sv
module xlt_match
   import xlt_pkg::*;
#(
   parameter int N_ENTRIES = 32,
   localparam int IDX_W = $clog2(N_ENTRIES)
) (
   input  xlt_entry_t        ents [N_ENTRIES],
   input  logic [VPN_W-1:0]  vpn,
   input  logic [ASID_W-1:0] asid,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   logic [N_ENTRIES-1:0] mvec;

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
      assign mvec[g] = ents[g].valid && (ents[g].vpn == vpn) &&
                       (ents[g].glb || (ents[g].asid == asid));
   end

   always_comb begin
      idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (mvec[i]) idx = IDX_W'(i);
      end
   end

   assign hit = |mvec;
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
   parameter int N_ENTRIES = 32,
   localparam int IDX_W = $clog2(N_ENTRIES),
   localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [IDX_W-1:0] wired,
   output logic [IDX_W-1:0] rnd_idx
);
   always_ff @(posedge clk) begin
      if (!rst_n)                rnd_idx <= TOP;
      else if (restart)          rnd_idx <= TOP;
      else if (rnd_idx <= wired) rnd_idx <= TOP;
      else                       rnd_idx <= rnd_idx - 1'b1;
   end
endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
   import xlt_pkg::*;
#(
   parameter int N_ENTRIES = 32,
   localparam int IDX_W = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_vld,
   input  logic [18:0]       lk_vpn,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [23:0]       lk_pfn,
   output logic              lk_dirty,
   output logic [2:0]        lk_coh,
   input  logic              cmd_vld,
   input  logic [2:0]        cmd_op,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [18:0]       cmd_vpn,
   input  logic [23:0]       cmd_pfn,
   input  logic [7:0]        cmd_asid,
   input  logic              cmd_glb,
   input  logic              cmd_dirty,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_coh,
   output logic              rsp_vld,
   output logic [31:0]       rsp_probe,
   output logic [18:0]       rsp_vpn,
   output logic [23:0]       rsp_pfn,
   output logic [7:0]        rsp_asid,
   output logic              rsp_glb,
   output logic              rsp_dirty,
   output logic              rsp_valid,
   output logic [2:0]        rsp_coh
);
   localparam logic [31:0] PROBE_MISS = 32'h8000_0000;

   if (N_ENTRIES != 32 && N_ENTRIES != 64) begin : g_bad_depth
      $error("xlt_cache: N_ENTRIES must be 32 or 64");
   end

   xlt_op_e          op;
   xlt_entry_t       ents_q [N_ENTRIES];
   xlt_entry_t       cmd_ent;
   xlt_entry_t       hit_ent;
   xlt_entry_t       rsp_ent_q;
   logic [ASID_W-1:0] cur_asid;
   logic [IDX_W-1:0] wired;
   logic [IDX_W-1:0] rnd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] pr_idx;
   logic             lk_any;
   logic             pr_any;
   logic             wr_en;
   logic             set_wired;

   assign op        = xlt_op_e'(cmd_op);
   assign cmd_ent   = '{vpn: cmd_vpn, pfn: cmd_pfn, asid: cmd_asid, glb: cmd_glb,
                        dirty: cmd_dirty, valid: cmd_valid, coh: cmd_coh};
   assign wr_en     = cmd_vld && (op == OP_WR_IDX || op == OP_WR_RND);
   assign wr_idx    = (op == OP_WR_RND) ? rnd_idx : cmd_idx;
   assign set_wired = cmd_vld && (op == OP_SET_WIRED);

   xlt_match #(.N_ENTRIES(N_ENTRIES)) u_lk_match (
      .ents(ents_q), .vpn(lk_vpn), .asid(cur_asid), .hit(lk_any), .idx(lk_idx)
   );

   xlt_match #(.N_ENTRIES(N_ENTRIES)) u_pr_match (
      .ents(ents_q), .vpn(cmd_vpn), .asid(cur_asid), .hit(pr_any), .idx(pr_idx)
   );

   xlt_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .restart(set_wired), .wired(wired), .rnd_idx(rnd_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENTRIES; i++) ents_q[i] <= '0;
      end else if (cmd_vld) begin
         if (op == OP_FLUSH) begin
            for (int i = 0; i < N_ENTRIES; i++) ents_q[i].valid <= 1'b0;
         end else if (wr_en) begin
            ents_q[wr_idx] <= cmd_ent;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_asid <= '0;
         wired    <= '0;
      end else if (cmd_vld) begin
         if (op == OP_SET_ASID)  cur_asid <= cmd_asid;
         if (op == OP_SET_WIRED) wired    <= cmd_idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_probe <= PROBE_MISS;
         rsp_ent_q <= '0;
      end else begin
         rsp_vld <= cmd_vld && (op == OP_PROBE || op == OP_READ);
         if (cmd_vld && op == OP_PROBE)
            rsp_probe <= pr_any ? 32'(pr_idx) : PROBE_MISS;
         if (cmd_vld && op == OP_READ)
            rsp_ent_q <= ents_q[cmd_idx];
      end
   end

   assign hit_ent  = ents_q[lk_idx];
   assign lk_hit   = lk_vld && lk_any;
   assign lk_miss  = lk_vld && !lk_any;
   assign lk_pfn   = lk_hit ? hit_ent.pfn   : '0;
   assign lk_dirty = lk_hit ? hit_ent.dirty : 1'b0;
   assign lk_coh   = lk_hit ? hit_ent.coh   : '0;

   assign rsp_vpn   = rsp_ent_q.vpn;
   assign rsp_pfn   = rsp_ent_q.pfn;
   assign rsp_asid  = rsp_ent_q.asid;
   assign rsp_glb   = rsp_ent_q.glb;
   assign rsp_dirty = rsp_ent_q.dirty;
   assign rsp_valid = rsp_ent_q.valid;
   assign rsp_coh   = rsp_ent_q.coh;
endmodule

// File: rtl/xlt_cache_chk.sv
module xlt_cache_chk #(
   parameter int N_ENTRIES = 32,
   localparam int IDX_W = $clog2(N_ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_hit,
   input logic             lk_miss,
   input logic             cmd_vld,
   input logic [2:0]       cmd_op,
   input logic [7:0]       cmd_asid,
   input logic             rsp_vld,
   input logic [31:0]      rsp_probe,
   input logic [IDX_W-1:0] rnd_idx,
   input logic [IDX_W-1:0] wired,
   input logic [7:0]       cur_asid
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss)); // R3
   AST_VICTIM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_idx >= wired); // R8
   AST_WIRED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 3'd6) |=> (rnd_idx == TOP)); // R9
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 3'd4) |=> !lk_hit); // R10
   AST_PROBE_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_probe[31]) |-> (rsp_probe[30:0] == 31'd0)); // R5
   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && (cmd_op == 3'd0 || cmd_op == 3'd1)) |=> rsp_vld); // R6
   AST_ASID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 3'd5) |=> (cur_asid == $past(cmd_asid))); // R4
   AST_ASID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_vld && cmd_op == 3'd5) |=> $stable(cur_asid)); // R4
endmodule

bind xlt_cache xlt_cache_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_miss(lk_miss),
   .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_asid(cmd_asid),
   .rsp_vld(rsp_vld), .rsp_probe(rsp_probe), .rnd_idx(rnd_idx),
   .wired(wired), .cur_asid(cur_asid)
);

// File: tb/sim_xlt_cache.sv
`timescale 1ns/1ps
module sim_xlt_cache;
   localparam int N = 32;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_vld = 1'b0;
   logic [18:0] lk_vpn = '0;
   logic lk_hit, lk_miss, lk_dirty;
   logic [23:0] lk_pfn;
   logic [2:0] lk_coh;
   logic cmd_vld = 1'b0;
   logic [2:0] cmd_op = 3'd7;
   logic [IW-1:0] cmd_idx = '0;
   logic [18:0] cmd_vpn = '0;
   logic [23:0] cmd_pfn = '0;
   logic [7:0] cmd_asid = '0;
   logic cmd_glb = 1'b0, cmd_dirty = 1'b0, cmd_valid = 1'b0;
   logic [2:0] cmd_coh = '0;
   logic rsp_vld, rsp_glb, rsp_dirty, rsp_valid;
   logic [31:0] rsp_probe;
   logic [18:0] rsp_vpn;
   logic [23:0] rsp_pfn;
   logic [7:0] rsp_asid;
   logic [2:0] rsp_coh;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xlt_cache #(.N_ENTRIES(N)) u0 (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input int idx, input logic [18:0] vpn,
                        input logic [23:0] pfn, input logic [7:0] asid, input logic glb,
                        input logic dirty, input logic [2:0] coh);
      cmd_vld = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_vpn = vpn; cmd_pfn = pfn;
      cmd_asid = asid; cmd_glb = glb; cmd_dirty = dirty; cmd_valid = 1'b1; cmd_coh = coh;
   endtask

   // one command, held for one cycle; responses are valid on return
   task automatic cmd1(input logic [2:0] op, input int idx, input logic [18:0] vpn,
                       input logic [23:0] pfn, input logic [7:0] asid, input logic glb,
                       input logic dirty, input logic [2:0] coh);
      @(negedge clk);
      drive(op, idx, vpn, pfn, asid, glb, dirty, coh);
      @(negedge clk);
      cmd_vld = 1'b0; cmd_op = 3'd7;
   endtask

   task automatic look(input string req, input logic [18:0] vpn, input logic exp_hit,
                       input logic [23:0] exp_pfn);
      @(negedge clk);
      lk_vld = 1'b1; lk_vpn = vpn;
      #1;
      chk(req, {lk_hit, lk_miss}, {exp_hit, ~exp_hit});
      if (exp_hit) chk(req, lk_pfn, exp_pfn);
      lk_vld = 1'b0;
   endtask

   task automatic t_reset;
      look("R1 lookup after reset", 19'h00000, 1'b0, 24'h0);
      cmd1(3'd1, 7, 0, 0, 0, 0, 0, 0);
      chk("R1 read valid after reset", {rsp_vld, rsp_valid}, 2'b10);
      cmd1(3'd0, 0, 19'h00000, 0, 0, 0, 0, 0);
      chk("R1 probe after reset", rsp_probe, 32'h8000_0000);
   endtask

   task automatic t_write_read;
      cmd1(3'd2, 5, 19'h12345, 24'hABCDEF, 8'h00, 1'b0, 1'b1, 3'd3);
      look("R7 R2 lookup written entry", 19'h12345, 1'b1, 24'hABCDEF);
      chk("R2 attribute bits", {lk_dirty, lk_coh}, {1'b1, 3'd3});
      cmd1(3'd1, 5, 0, 0, 0, 0, 0, 0);
      chk("R6 read fields", {rsp_vld, rsp_vpn, rsp_pfn, rsp_asid, rsp_glb, rsp_dirty, rsp_valid, rsp_coh},
          {1'b1, 19'h12345, 24'hABCDEF, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3});
      cmd1(3'd7, 5, 19'h12345, 24'h111111, 8'h00, 1'b0, 1'b0, 3'd0);
      look("R11 nop leaves entry", 19'h12345, 1'b1, 24'hABCDEF);
   endtask

   task automatic t_asid;
      cmd1(3'd5, 0, 0, 0, 8'h07, 0, 0, 0);
      look("R4 R3 other identifier misses", 19'h12345, 1'b0, 24'h0);
      cmd1(3'd2, 9, 19'h00100, 24'h000777, 8'h03, 1'b1, 1'b0, 3'd1);
      look("R2 global entry hits any identifier", 19'h00100, 1'b1, 24'h000777);
      cmd1(3'd2, 10, 19'h00200, 24'h000888, 8'h07, 1'b0, 1'b0, 3'd0);
      look("R4 current identifier entry hits", 19'h00200, 1'b1, 24'h000888);
      cmd1(3'd5, 0, 0, 0, 8'h00, 0, 0, 0);
      look("R4 identifier 0 hits again", 19'h12345, 1'b1, 24'hABCDEF);
      look("R4 identifier 7 entry now misses", 19'h00200, 1'b0, 24'h0);
   endtask

   task automatic t_probe;
      cmd1(3'd0, 0, 19'h12345, 0, 0, 0, 0, 0);
      chk("R5 probe index", {rsp_vld, rsp_probe}, {1'b1, 32'd5});
      cmd1(3'd2, 2, 19'h12345, 24'h222222, 8'h00, 1'b0, 1'b0, 3'd0);
      cmd1(3'd0, 0, 19'h12345, 0, 0, 0, 0, 0);
      chk("R5 lowest matching index", rsp_probe, 32'd2);
      cmd1(3'd0, 0, 19'h7FFFF, 0, 0, 0, 0, 0);
      chk("R5 probe miss code", rsp_probe, 32'h8000_0000);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      drive(3'd2, 20, 19'h55555, 24'h0F0F0F, 8'h00, 1'b0, 1'b0, 3'd2);
      lk_vld = 1'b1; lk_vpn = 19'h55555;
      #1;
      chk("R11 same-cycle lookup sees old contents", {lk_hit, lk_miss}, 2'b01);
      @(negedge clk);
      cmd_vld = 1'b0; cmd_op = 3'd7;
      #1;
      chk("R11 next-cycle lookup sees write", {lk_hit, lk_pfn}, {1'b1, 24'h0F0F0F});
      lk_vld = 1'b0;
   endtask

   task automatic t_random;
      @(negedge clk);
      drive(3'd6, N - 2, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      drive(3'd3, 0, 19'h0000A, 24'h00000A, 8'h00, 1'b0, 1'b0, 3'd0);
      @(negedge clk);
      drive(3'd3, 0, 19'h0000B, 24'h00000B, 8'h00, 1'b0, 1'b0, 3'd0);
      @(negedge clk);
      drive(3'd3, 0, 19'h0000C, 24'h00000C, 8'h00, 1'b0, 1'b0, 3'd0);
      @(negedge clk);
      cmd_vld = 1'b0; cmd_op = 3'd7;
      cmd1(3'd1, N - 1, 0, 0, 0, 0, 0, 0);
      chk("R9 R8 top index written twice after wrap", {rsp_valid, rsp_vpn}, {1'b1, 19'h0000C});
      cmd1(3'd1, N - 2, 0, 0, 0, 0, 0, 0);
      chk("R8 victim reaches wired boundary", {rsp_valid, rsp_vpn}, {1'b1, 19'h0000B});
      cmd1(3'd1, N - 3, 0, 0, 0, 0, 0, 0);
      chk("R8 entry below wired untouched", rsp_valid, 1'b0);
      cmd1(3'd1, 5, 0, 0, 0, 0, 0, 0);
      chk("R8 low wired entry kept", {rsp_valid, rsp_vpn}, {1'b1, 19'h12345});
      look("R8 random entry translates", 19'h0000B, 1'b1, 24'h00000B);
   endtask

   task automatic t_flush;
      cmd1(3'd4, 0, 0, 0, 0, 0, 0, 0);
      look("R10 tagged entry gone", 19'h12345, 1'b0, 24'h0);
      look("R10 global entry gone", 19'h00100, 1'b0, 24'h0);
      cmd1(3'd1, 5, 0, 0, 0, 0, 0, 0);
      chk("R10 read shows invalid", rsp_valid, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_asid();
      t_probe();
      t_same_cycle();
      t_random();
      t_flush();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule